// File: doc/BRIEF.md
# Cache-Line Access Splitter

This block takes a single memory access and breaks it into fragments that each stay inside one cache line. The access is a start address, a byte count, an optional per-byte enable vector and a kind: load, store or atomic. The block issues the fragments in ascending address order on a valid/ready port. A downstream port may refuse a fragment. When that happens the block keeps the same fragment on offer and carries on from it once the port accepts it. Fragments that were already sent are never built again.

Each fragment reports four things:
- its address and byte size;
- its byte offset from the start of the access, so the caller can place data in its access buffer;
- the slice of byte enables that covers its own bytes;
- a flag that marks the final fragment.

The block counts sent fragments against returned responses. It pulses a completion strobe once every fragment has been answered. It refuses three kinds of access at the input: a zero-size access, an oversize access, and an atomic access that would need more than one line.

Top module: `line_splitter`

## Requirements
- R1: After reset `acc_ready` is 1, while `frag_valid`, `done` and `outstanding` are 0. `acc_ready` is 1 exactly when no access is in progress.
- R2: Every fragment fits inside one line: (address modulo LINE_BYTES) + size is at most LINE_BYTES, and the size is nonzero.
- R3: Fragments are contiguous and in ascending address order. The first fragment runs from the start address to the next line boundary, or covers the whole access if that is smaller. The fragments after it are full lines. A final partial fragment holds whatever bytes remain.
- R4: `frag_offset` equals the fragment address minus the access start address.
- R5: For i below the fragment size, bit i of `frag_be` equals bit (offset+i) of the access enable vector when `acc_be_use` is 1, and is 1 otherwise. Bits at or above the size are 0.
- R6: `frag_last` is 1 on the final fragment of an access and 0 on every other fragment.
- R7: A refused fragment (`frag_valid` 1, `frag_ready` 0) stays on offer with the same address, size, offset and enables in the next cycle.
- R8: Three kinds of access are refused. The first is size 0. The second is a size above MAX_SIZE. The third is `acc_kind` = 2 (atomic; 0 is load, 1 is store) when (address modulo LINE_BYTES) + size exceeds LINE_BYTES. For a refused access, `acc_err` is 1 in the same cycle as `acc_valid`, no fragment is emitted and the block stays idle.
- R9: A response pulse counts only while at least one fragment is outstanding; any other pulse is ignored. `done` is 1 for exactly one cycle, when all fragments are sent and all have been answered. The block is idle in the following cycle.
- R10: `outstanding` equals the number of accepted fragments minus the number of counted responses for the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block idle, access can be taken |
| acc_addr | input | ADDR_W | Start byte address |
| acc_size | input | SZ_W | Byte count |
| acc_kind | input | 2 | 0 load, 1 store, 2 atomic |
| acc_be | input | MAX_SIZE | Per-byte enables, bit 0 = first byte |
| acc_be_use | input | 1 | Enables present |
| acc_err | output | 1 | Offered access is illegal and refused |
| frag_valid | output | 1 | Fragment on offer |
| frag_ready | input | 1 | Downstream accepts the fragment |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_size | output | SZ_W | Fragment byte count |
| frag_offset | output | SZ_W | Offset from the access start |
| frag_be | output | LINE_BYTES | Enable slice, bit 0 = fragment's first byte |
| frag_last | output | 1 | Final fragment of the access |
| rsp_valid | input | 1 | One response returned |
| outstanding | output | CNT_W | Fragments sent but not yet answered |
| done | output | 1 | Every fragment answered |

## Verification
The assertions assume two things about the inputs. First, `frag_ready` may change freely, but the environment never withdraws a response it has already counted. Second, `acc_valid` is only meaningful while `acc_ready` is 1. The stimulus keeps to both. It offers an access only when the block is idle, raises `acc_valid` for a single cycle, and drives a refusal pattern on `frag_ready` that always lets progress resume within a few cycles.

The sweep covers every in-line start offset and every size from 0 to one above MAX_SIZE, for each of the three access kinds. It also sends a response pulse when nothing is outstanding, so that the ignore rule is exercised on every access.

// File: rtl/line_split_pkg.sv
package line_split_pkg;
   typedef enum logic [1:0] {
      KIND_LOAD   = 2'd0,
      KIND_STORE  = 2'd1,
      KIND_ATOMIC = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/line_split_cursor.sv
// Walks an access one fragment at a time; each step is clipped to the line.
module line_split_cursor #(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 8,
   parameter int SZ_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [SZ_W-1:0]   ld_size,
   input  logic              advance,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [SZ_W-1:0]   step_size,
   output logic [SZ_W-1:0]   cur_off,
   output logic              rem_zero,
   output logic              is_last
);
   localparam int LW = $clog2(LINE_BYTES);
   localparam int CW = (SZ_W > LW + 1) ? SZ_W : LW + 1;

   logic [SZ_W-1:0] rem_q;
   logic [CW-1:0]   room;
   logic [CW-1:0]   rem_w;

   assign room  = CW'(LINE_BYTES) - CW'(cur_addr[LW-1:0]);
   assign rem_w = CW'(rem_q);
   assign step_size = (rem_w < room) ? rem_q : SZ_W'(room);
   assign rem_zero  = (rem_q == '0);
   assign is_last   = !rem_zero && (step_size == rem_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         rem_q    <= '0;
         cur_off  <= '0;
      end else if (load) begin
         cur_addr <= ld_addr;
         rem_q    <= ld_size;
         cur_off  <= '0;
      end else if (advance && !rem_zero) begin
         cur_addr <= cur_addr + ADDR_W'(step_size);
         rem_q    <= rem_q - step_size;
         cur_off  <= cur_off + step_size;
      end
   end
endmodule

// File: rtl/line_split_track.sv
// Counts sent fragments and matching responses for the access in flight.
module line_split_track #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] ld_total,
   input  logic             sent,
   input  logic             rsp,
   output logic [CNT_W-1:0] outstanding,
   output logic             all_rcvd
);
   logic [CNT_W-1:0] total_q, sent_q, rcv_q;
   logic             rsp_take;

   assign rsp_take    = rsp && (rcv_q < sent_q);
   assign outstanding = sent_q - rcv_q;
   assign all_rcvd    = (rcv_q == total_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q <= '0;
         sent_q  <= '0;
         rcv_q   <= '0;
      end else if (load) begin
         total_q <= ld_total;
         sent_q  <= '0;
         rcv_q   <= '0;
      end else begin
         if (sent)     sent_q <= sent_q + 1'b1;
         if (rsp_take) rcv_q  <= rcv_q + 1'b1;
      end
   end
endmodule

// File: rtl/line_split_be.sv
// Picks the enable slice for the current fragment and masks unused lanes.
module line_split_be #(
   parameter int MAX_SIZE   = 32,
   parameter int LINE_BYTES = 8,
   parameter int SZ_W       = 6,
   parameter bit HAS_BE     = 1'b1
) (
   input  logic [MAX_SIZE-1:0]   be_vec,
   input  logic                  be_use,
   input  logic [SZ_W-1:0]       off,
   input  logic [SZ_W-1:0]       size,
   output logic [LINE_BYTES-1:0] be_out
);
   logic [MAX_SIZE-1:0] shifted;
   assign shifted = be_vec >> off;

   for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
      logic in_range;
      assign in_range = (SZ_W'(i) < size);
      if (HAS_BE) begin : g_sel
         assign be_out[i] = in_range && (!be_use || shifted[i]);
      end else begin : g_all
         logic unused_b;
         assign unused_b  = be_use ^ shifted[i];
         assign be_out[i] = in_range;
      end
   end
endmodule

// File: rtl/line_splitter.sv
module line_splitter #(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 8,
   parameter int MAX_SIZE   = 32,
   parameter bit HAS_BE     = 1'b1,
   localparam int SZ_W      = $clog2(MAX_SIZE + 1),
   localparam int MAX_FRAGS = (MAX_SIZE + 2 * LINE_BYTES - 2) / LINE_BYTES,
   localparam int CNT_W     = $clog2(MAX_FRAGS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   output logic                  acc_ready,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [SZ_W-1:0]       acc_size,
   input  logic [1:0]            acc_kind,
   input  logic [MAX_SIZE-1:0]   acc_be,
   input  logic                  acc_be_use,
   output logic                  acc_err,
   output logic                  frag_valid,
   input  logic                  frag_ready,
   output logic [ADDR_W-1:0]     frag_addr,
   output logic [SZ_W-1:0]       frag_size,
   output logic [SZ_W-1:0]       frag_offset,
   output logic [LINE_BYTES-1:0] frag_be,
   output logic                  frag_last,
   input  logic                  rsp_valid,
   output logic [CNT_W-1:0]      outstanding,
   output logic                  done
);
   import line_split_pkg::*;

   localparam int LW   = $clog2(LINE_BYTES);
   localparam int SP_W = SZ_W + 2;

   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (MAX_SIZE < LINE_BYTES) begin : g_bad_max
      $error("MAX_SIZE must be at least LINE_BYTES");
   end
   if (ADDR_W <= LW) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic                busy_q;
   logic [MAX_SIZE-1:0] be_q;
   logic                be_use_q;
   logic                illegal, accept, fire, rem_zero, all_rcvd;
   logic [SP_W-1:0]     in_line_end, span;
   logic [CNT_W-1:0]    n_frags;

   assign in_line_end = SP_W'(acc_addr[LW-1:0]) + SP_W'(acc_size);
   assign span        = in_line_end + SP_W'(LINE_BYTES - 1);
   assign n_frags     = CNT_W'(span >> LW);

   assign illegal = (acc_size == '0)
                 || (SP_W'(acc_size) > SP_W'(MAX_SIZE))
                 || ((acc_kind == KIND_ATOMIC) && (in_line_end > SP_W'(LINE_BYTES)));

   assign acc_ready  = !busy_q;
   assign acc_err    = acc_valid && !busy_q && illegal;
   assign accept     = acc_valid && !busy_q && !illegal;
   assign frag_valid = busy_q && !rem_zero;
   assign fire       = frag_valid && frag_ready;
   assign done       = busy_q && rem_zero && all_rcvd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         be_q     <= '0;
         be_use_q <= 1'b0;
      end else if (accept) begin
         busy_q   <= 1'b1;
         be_q     <= acc_be;
         be_use_q <= acc_be_use;
      end else if (done) begin
         busy_q   <= 1'b0;
      end
   end

   line_split_cursor #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SZ_W(SZ_W)
   ) u_cursor (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .ld_addr   (acc_addr),
      .ld_size   (acc_size),
      .advance   (fire),
      .cur_addr  (frag_addr),
      .step_size (frag_size),
      .cur_off   (frag_offset),
      .rem_zero  (rem_zero),
      .is_last   (frag_last)
   );

   line_split_track #(.CNT_W(CNT_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (accept),
      .ld_total    (n_frags),
      .sent        (fire),
      .rsp         (rsp_valid && busy_q),
      .outstanding (outstanding),
      .all_rcvd    (all_rcvd)
   );

   line_split_be #(
      .MAX_SIZE(MAX_SIZE), .LINE_BYTES(LINE_BYTES), .SZ_W(SZ_W), .HAS_BE(HAS_BE)
   ) u_be (
      .be_vec (be_q),
      .be_use (be_use_q),
      .off    (frag_offset),
      .size   (frag_size),
      .be_out (frag_be)
   );
endmodule

// File: rtl/line_splitter_chk.sv
module line_splitter_chk #(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 8,
   parameter int SZ_W       = 6,
   parameter int CNT_W      = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_ready,
   input logic              acc_err,
   input logic              frag_valid,
   input logic              frag_ready,
   input logic [ADDR_W-1:0] frag_addr,
   input logic [SZ_W-1:0]   frag_size,
   input logic [SZ_W-1:0]   frag_offset,
   input logic [CNT_W-1:0]  outstanding,
   input logic              done
);
   localparam int LW = $clog2(LINE_BYTES);

   p_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frag_valid |-> ((frag_size != '0) &&
         ((SZ_W + 1)'(frag_addr[LW-1:0]) + (SZ_W + 1)'(frag_size) <= (SZ_W + 1)'(LINE_BYTES))));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_addr)
         && $stable(frag_size) && $stable(frag_offset)));

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ready |-> (!frag_valid && !done && outstanding == '0));

   p_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> (acc_ready && !frag_valid));

   p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (acc_ready && !done));

   p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (outstanding == '0 && !frag_valid));
endmodule

bind line_splitter line_splitter_chk #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SZ_W(SZ_W), .CNT_W(CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_ready   (acc_ready),
   .acc_err     (acc_err),
   .frag_valid  (frag_valid),
   .frag_ready  (frag_ready),
   .frag_addr   (frag_addr),
   .frag_size   (frag_size),
   .frag_offset (frag_offset),
   .outstanding (outstanding),
   .done        (done)
);

// File: tb/sim_line_splitter.sv
`timescale 1ns/1ps
module sim_line_splitter;
   localparam int ADDR_W = 16;
   localparam int LINE   = 8;
   localparam int MAXS   = 32;
   localparam int SZ_W   = $clog2(MAXS + 1);
   localparam int MAXF   = (MAXS + 2 * LINE - 2) / LINE;
   localparam int CNT_W  = $clog2(MAXF + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [SZ_W-1:0] acc_size = '0;
   logic [1:0] acc_kind = '0;
   logic [MAXS-1:0] acc_be = '0;
   logic acc_be_use = 1'b0;
   logic frag_ready = 1'b0;
   logic rsp_valid = 1'b0;
   logic acc_ready, acc_err, frag_valid, frag_last, done;
   logic [ADDR_W-1:0] frag_addr;
   logic [SZ_W-1:0] frag_size, frag_offset;
   logic [LINE-1:0] frag_be;
   logic [CNT_W-1:0] outstanding;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   line_splitter #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .MAX_SIZE(MAXS)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
      .acc_be(acc_be), .acc_be_use(acc_be_use), .acc_err(acc_err),
      .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
      .frag_size(frag_size), .frag_offset(frag_offset), .frag_be(frag_be),
      .frag_last(frag_last), .rsp_valid(rsp_valid), .outstanding(outstanding),
      .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(input int aoff, input int sz, input int kind);
      int addr, cur, rem, off, sent, rcv, step, room, fs, expbe, rdy, rsp;
      bit ill, refused, fin;
      logic [MAXS-1:0] bev;
      addr = 16'h7FF0 + aoff;
      bev  = 32'hA5C3_96E1 ^ (32'(aoff) * 32'h0101_0101) ^ (32'(sz) << 7);
      ill  = (sz == 0) || (sz > MAXS) || (kind == 2 && aoff + sz > LINE);
      @(negedge clk);
      chk(acc_ready == 1'b1, "R1 ready when idle", int'(acc_ready), 1);
      acc_valid = 1'b1; acc_addr = ADDR_W'(addr); acc_size = SZ_W'(sz);
      acc_kind = 2'(kind); acc_be = bev; acc_be_use = (kind == 1);
      #1;
      chk(acc_err == ill, "R8 error flag", int'(acc_err), int'(ill));
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
      if (ill) begin
         chk(frag_valid == 1'b0 && acc_ready == 1'b1, "R8 nothing emitted",
             int'(frag_valid), 0);
         return;
      end
      cur = addr; rem = sz; off = 0; sent = 0; rcv = 0; step = 0;
      refused = 1'b0; fin = 1'b0;
      while (!fin) begin
         chk(int'(outstanding) == sent - rcv, "R10 outstanding",
             int'(outstanding), sent - rcv);
         rdy = 0;
         if (rem > 0) begin
            room = LINE - (cur % LINE);
            fs = (rem < room) ? rem : room;
            expbe = 0;
            for (int i = 0; i < fs; i++)
               if (kind != 1 || bev[off + i]) expbe |= (1 << i);
            chk(frag_valid == 1'b1, "R3 fragment offered", int'(frag_valid), 1);
            chk(int'(frag_addr) == cur, refused ? "R7 held address" : "R3 address",
                int'(frag_addr), cur);
            chk(int'(frag_size) == fs, "R2 size within line", int'(frag_size), fs);
            chk(int'(frag_offset) == off, "R4 offset", int'(frag_offset), off);
            chk(int'(frag_be) == expbe, "R5 enable slice", int'(frag_be), expbe);
            chk(frag_last == (fs == rem), "R6 last flag", int'(frag_last),
                int'(fs == rem));
            rdy = (((step * 5 + sz + aoff) % 4) == 3) ? 0 : 1;
         end else begin
            chk(frag_valid == 1'b0, "R3 no extra fragment", int'(frag_valid), 0);
         end
         fin = (rem == 0) && (rcv == sent);
         chk(done == fin, "R9 done timing", int'(done), int'(fin));
         if (!fin) begin
            rsp = (rem > 0) ? int'(step % 2 == 0) : 1;
            frag_ready = rdy[0];
            rsp_valid  = rsp[0];
            @(posedge clk);
            if (rsp != 0 && sent > rcv) rcv++;
            refused = (rem > 0) && (rdy == 0);
            if (rem > 0 && rdy != 0) begin
               cur += fs; rem -= fs; off += fs; sent++;
            end
            @(negedge clk);
            frag_ready = 1'b0;
            rsp_valid  = 1'b0;
            step++;
         end
      end
      @(posedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(acc_ready == 1'b1, "R1 reset ready", int'(acc_ready), 1);
      chk(frag_valid == 1'b0, "R1 reset frag_valid", int'(frag_valid), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk(outstanding == '0, "R1 reset outstanding", int'(outstanding), 0);
      for (int kind = 0; kind < 3; kind++)
         for (int aoff = 0; aoff < LINE; aoff++)
            for (int sz = 0; sz <= MAXS + 1; sz++)
               run(aoff, sz, kind);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule